// File: doc/BRIEF.md
# Time-of-Day Counter with Command Port

This block keeps the running time of day for a timing-aware network device. It consists of a 48-bit seconds count and a 30-bit nanoseconds count. Each reference tick advances the time by a fixed number of nanoseconds. A separate drift-correction block can stretch or shrink that step by one nanosecond on any tick. When the nanoseconds reach one second, they wrap and the seconds count carries.

Software reaches the clock through a small write port. The port holds three staging registers: upper seconds, lower seconds and nanoseconds. It also holds a one-shot command register. A command can freeze a copy of the live time into the staging registers. It can also overwrite the live time with the staged value, or shift the live time by a signed nanosecond offset. Seconds and nanoseconds always move together, so no reading or setting is ever split across a second boundary.

After a backward shift, the nanosecond field may be left a few nanoseconds below zero. In that case the block keeps the small negative value as it is and does not borrow a second. The following ticks then bring the field back to a positive count within the same second.

Top module: `tod_clock`

## Requirements
- R1: While reset is high and after it, live seconds, live nanoseconds, all three staging registers and the pending command read zero. Zero is the idle command.
- R2: A tick with the correction input low adds NOM_INC ns. A tick with correction high and the slow select high adds NOM_INC-1 ns. A tick with correction high and the slow select low adds NOM_INC+1 ns. With no tick and no LOAD or DELTA command, the live time holds.
- R3: If the nanoseconds reach 1,000,000,000 or more, 1,000,000,000 is subtracted and the 48-bit seconds count increments, carrying across its bit-32 boundary.
- R4: The write address selects the target. Address 0 selects nanoseconds (data bits 29:0). Address 1 selects lower seconds (bits 31:0). Address 2 selects upper seconds (bits 15:0). Address 3 selects the command (bits 1:0: 0 idle, 1 save, 2 load, 3 delta). Staging registers read back on their outputs.
- R5: A written command shows on the pending output for exactly one cycle. It takes effect at the next clock edge, after which the pending output returns to idle.
- R6: SAVE copies the live seconds and nanoseconds, as they stand just before the execution edge, into the staging registers in one step.
- R7: LOAD replaces the live time with {upper, lower} seconds and the staged nanoseconds in one step. A tick in that cycle is dropped.
- R8: DELTA adds the staged nanoseconds, read as a signed 30-bit value, to the live time together with any tick in the same cycle. The staged seconds registers are ignored.
- R9: If a DELTA result falls below -16 ns, 1,000,000,000 is added and the seconds count decrements.
- R10: If a result lies in -16 to -1 ns, it is stored as its 30-bit two's complement (0x3FFFFFF0 to 0x3FFFFFFF) and the seconds are unchanged. Later ticks add to the signed value.
- R11: A DELTA whose signed offset has a magnitude of 500,000,000 ns or more has no effect on the live time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Advance the time on this cycle |
| corr_valid | input | 1 | Apply a one-nanosecond correction to this tick |
| corr_slow | input | 1 | Correction direction: 1 shortens the step, 0 lengthens it |
| wr_en | input | 1 | Write strobe for the access port |
| wr_addr | input | 2 | Access register select |
| wr_data | input | 32 | Write data |
| acc_sec_hi | output | 16 | Staged upper seconds |
| acc_sec_lo | output | 32 | Staged lower seconds |
| acc_ns | output | 30 | Staged nanoseconds |
| act_pend | output | 2 | Command waiting to execute at the next edge |
| live_sec | output | 48 | Running seconds |
| live_ns | output | 30 | Running nanoseconds |

## Verification
The window property on the live nanoseconds assumes that software only loads nanosecond values below one second. The bench therefore loads only such values. The save and load properties assume that no staging register is written on the same edge that a SAVE executes. The bench avoids this by waiting one full cycle after every command write before the next write. Ticks are held low around each DELTA so that the property checking that far offsets are ignored sees quiet cycles. A separate directed case runs the clock during a SAVE to confirm that the capture is atomic.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int SEC_W      = 48;
    localparam int NS_W       = 30;
    localparam int BUS_W      = 32;
    localparam int SEC_HI_W   = SEC_W - BUS_W;
    localparam int ADDR_W     = 2;
    localparam int NEG_WIN    = 16;
    localparam int NS_PER_SEC_I = 1_000_000_000;

    localparam logic [NS_W-1:0] NS_PER_SEC = NS_W'(NS_PER_SEC_I);
    localparam logic [NS_W-1:0] NEG_START  = NS_W'((1 << NS_W) - NEG_WIN);

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_SAVE  = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_DELTA = 2'd3
    } tod_act_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_NS     = 2'd0,
        REG_SEC_LO = 2'd1,
        REG_SEC_HI = 2'd2,
        REG_ACTION = 2'd3
    } tod_reg_e;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } tod_t;

endpackage

// File: rtl/tod_access_regs.sv
module tod_access_regs
    import tod_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BUS_W-1:0]    wr_data,
    input  logic                save_en,
    input  tod_t                save_val,
    output logic [SEC_HI_W-1:0] sec_hi_q,
    output logic [BUS_W-1:0]    sec_lo_q,
    output logic [NS_W-1:0]     ns_q,
    output tod_act_e            act_q
);

    logic act_wr;
    assign act_wr = wr_en && (wr_addr == REG_ACTION);

    // Command register: one-shot, falls back to idle unless rewritten
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= ACT_IDLE;
        end else if (act_wr) begin
            act_q <= tod_act_e'(wr_data[1:0]);
        end else begin
            act_q <= ACT_IDLE;
        end
    end

    // Staging registers: a capture takes precedence over software writes
    always_ff @(posedge clk) begin
        if (rst) begin
            sec_hi_q <= '0;
            sec_lo_q <= '0;
            ns_q     <= '0;
        end else if (save_en) begin
            sec_hi_q <= save_val.sec[SEC_W-1:BUS_W];
            sec_lo_q <= save_val.sec[BUS_W-1:0];
            ns_q     <= save_val.ns;
        end else if (wr_en) begin
            case (wr_addr)
                REG_NS:     ns_q     <= wr_data[NS_W-1:0];
                REG_SEC_LO: sec_lo_q <= wr_data;
                REG_SEC_HI: sec_hi_q <= wr_data[SEC_HI_W-1:0];
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/tod_next_time.sv
module tod_next_time
    import tod_pkg::*;
#(
    parameter int NOM_INC = 8
) (
    input  tod_t            cur,
    input  logic            tick,
    input  logic            corr_valid,
    input  logic            corr_slow,
    input  logic            apply_delta,
    input  logic [NS_W-1:0] offset,
    output tod_t            nxt
);

    localparam int SW  = NS_W + 3;
    localparam int EXT = SW - NS_W;
    localparam logic signed [SW-1:0] ONE_SEC   = SW'(NS_PER_SEC_I);
    localparam logic signed [SW-1:0] HALF_SEC  = SW'(NS_PER_SEC_I / 2);
    localparam logic signed [SW-1:0] NEG_FLOOR = SW'(-NEG_WIN);
    localparam logic signed [SW-1:0] INC_NOM   = SW'(NOM_INC);

    logic signed [SW-1:0] cur_s;
    logic signed [SW-1:0] inc_s;
    logic signed [SW-1:0] off_s;
    logic signed [SW-1:0] off_sel;
    logic signed [SW-1:0] sum_s;
    logic                 off_ok;

    always_comb begin
        // a field in the top window is a small negative count
        if (cur.ns >= NEG_START) begin
            cur_s = {{EXT{1'b1}}, cur.ns};
        end else begin
            cur_s = {{EXT{1'b0}}, cur.ns};
        end

        off_s  = {{EXT{offset[NS_W-1]}}, offset};
        off_ok = apply_delta && (off_s < HALF_SEC) && (off_s > -HALF_SEC);
        off_sel = off_ok ? off_s : {SW{1'b0}};

        if (!tick) begin
            inc_s = {SW{1'b0}};
        end else if (!corr_valid) begin
            inc_s = INC_NOM;
        end else if (corr_slow) begin
            inc_s = INC_NOM - SW'(1);
        end else begin
            inc_s = INC_NOM + SW'(1);
        end

        sum_s = cur_s + inc_s + off_sel;

        nxt = cur;
        if (sum_s >= ONE_SEC) begin
            nxt.ns  = NS_W'(sum_s - ONE_SEC);
            nxt.sec = cur.sec + 1'b1;
        end else if (sum_s < NEG_FLOOR) begin
            nxt.ns  = NS_W'(sum_s + ONE_SEC);
            nxt.sec = cur.sec - 1'b1;
        end else begin
            nxt.ns  = sum_s[NS_W-1:0];
        end
    end

endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int NOM_INC = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                corr_valid,
    input  logic                corr_slow,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [31:0]         wr_data,
    output logic [15:0]         acc_sec_hi,
    output logic [31:0]         acc_sec_lo,
    output logic [29:0]         acc_ns,
    output logic [1:0]          act_pend,
    output logic [47:0]         live_sec,
    output logic [29:0]         live_ns
);

    tod_t     live_q;
    tod_t     step_nxt;
    tod_t     staged;
    tod_act_e act_q;

    tod_access_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .save_en  (act_q == ACT_SAVE),
        .save_val (live_q),
        .sec_hi_q (acc_sec_hi),
        .sec_lo_q (acc_sec_lo),
        .ns_q     (acc_ns),
        .act_q    (act_q)
    );

    tod_next_time #(.NOM_INC(NOM_INC)) u_step (
        .cur         (live_q),
        .tick        (tick),
        .corr_valid  (corr_valid),
        .corr_slow   (corr_slow),
        .apply_delta (act_q == ACT_DELTA),
        .offset      (acc_ns),
        .nxt         (step_nxt)
    );

    assign staged.sec = {acc_sec_hi, acc_sec_lo};
    assign staged.ns  = acc_ns;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
        end else if (act_q == ACT_LOAD) begin
            live_q <= staged;
        end else begin
            live_q <= step_nxt;
        end
    end

    assign act_pend = act_q;
    assign live_sec = live_q.sec;
    assign live_ns  = live_q.ns;

endmodule

// File: rtl/tod_clock_checker.sv
module tod_clock_checker
    import tod_pkg::*;
#(
    parameter int NOM_INC = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        corr_valid,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [15:0] acc_sec_hi,
    input logic [31:0] acc_sec_lo,
    input logic [29:0] acc_ns,
    input logic [1:0]  act_pend,
    input logic [47:0] live_sec,
    input logic [29:0] live_ns
);

    localparam logic [NS_W-1:0] HALF_POS = NS_W'(NS_PER_SEC_I / 2);
    localparam logic [NS_W-1:0] HALF_NEG = NS_W'((1 << NS_W) - NS_PER_SEC_I / 2);

    logic far_offset;
    assign far_offset = acc_ns[NS_W-1] ? (acc_ns <= HALF_NEG) : (acc_ns >= HALF_POS);

    assert_ns_window_R10: assert property (@(posedge clk) disable iff (rst)
        (live_ns < NS_PER_SEC) || (live_ns >= NEG_START));

    assert_cmd_one_shot_R5: assert property (@(posedge clk) disable iff (rst)
        (act_pend != 2'd0 && !(wr_en && wr_addr == 2'd3)) |=> (act_pend == 2'd0));

    assert_save_copy_R6: assert property (@(posedge clk) disable iff (rst)
        (act_pend == 2'd1) |=> ({acc_sec_hi, acc_sec_lo} == $past(live_sec)) && (acc_ns == $past(live_ns)));

    assert_load_copy_R7: assert property (@(posedge clk) disable iff (rst)
        (act_pend == 2'd2) |=> (live_sec == {$past(acc_sec_hi), $past(acc_sec_lo)}) && (live_ns == $past(acc_ns)));

    assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && act_pend[1] == 1'b0) |=> $stable(live_sec) && $stable(live_ns));

    assert_plain_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !corr_valid && act_pend[1] == 1'b0 && live_ns < NS_PER_SEC - NS_W'(NOM_INC))
        |=> (live_ns == $past(live_ns) + NS_W'(NOM_INC)) && $stable(live_sec));

    assert_far_offset_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (act_pend == 2'd3 && !tick && far_offset) |=> $stable(live_sec) && $stable(live_ns));

endmodule

bind tod_clock tod_clock_checker #(.NOM_INC(NOM_INC)) u_tod_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .corr_valid (corr_valid),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .acc_sec_hi (acc_sec_hi),
    .acc_sec_lo (acc_sec_lo),
    .acc_ns     (acc_ns),
    .act_pend   (act_pend),
    .live_sec   (live_sec),
    .live_ns    (live_ns)
);

// File: tb/test_tod_clock.sv
`timescale 1ns/1ps
module test_tod_clock;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        corr_valid = 1'b0;
    logic        corr_slow = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [15:0] acc_sec_hi;
    logic [31:0] acc_sec_lo;
    logic [29:0] acc_ns;
    logic [1:0]  act_pend;
    logic [47:0] live_sec;
    logic [29:0] live_ns;

    int n_checks = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tod_clock #(.NOM_INC(8)) i_tod_clock (
        .clk(clk), .rst(rst), .tick(tick), .corr_valid(corr_valid), .corr_slow(corr_slow),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .acc_sec_hi(acc_sec_hi), .acc_sec_lo(acc_sec_lo), .acc_ns(acc_ns),
        .act_pend(act_pend), .live_sec(live_sec), .live_ns(live_ns)
    );

    typedef struct packed {
        logic [47:0] sec;
        logic [29:0] ns;
        logic [7:0]  nticks;
        logic [1:0]  corr;   // 0 none, 1 lengthen, 2 shorten
        logic [31:0] delta;
        logic [47:0] exp_sec;
        logic [29:0] exp_ns;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{48'd5,           30'd100,        8'd10, 2'd0, 32'd0,          48'd5,            30'd180},        // R2
        '{48'd7,           30'd999999990,  8'd2,  2'd0, 32'd0,          48'd8,            30'd6},          // R3
        '{48'hFFFFFFFF,    30'd999999995,  8'd1,  2'd1, 32'd0,          48'h100000000,    30'd4},          // R3 R2
        '{48'd10,          30'd1000,       8'd4,  2'd2, 32'd0,          48'd10,           30'd1028},       // R2
        '{48'd20,          30'd500,        8'd0,  2'd0, 32'd1000,       48'd20,           30'd1500},       // R8
        '{48'd20,          30'd500,        8'd0,  2'd0, -32'sd600,      48'd19,           30'd999999900},  // R9
        '{48'd20,          30'd500,        8'd0,  2'd0, -32'sd505,      48'd20,           30'h3FFFFFFB},   // R10
        '{48'd30,          30'd999000000,  8'd0,  2'd0, 32'd2000000,    48'd31,           30'd1000000},    // R8 R3
        '{48'd40,          30'd1000,       8'd0,  2'd0, 32'd499999999,  48'd40,           30'd500000999},  // R8
        '{48'd40,          30'd1000,       8'd0,  2'd0, -32'sd499999999,48'd39,           30'd500001001},  // R9
        '{48'd50,          30'd1000,       8'd0,  2'd0, 32'd500000000,  48'd50,           30'd1000},       // R11
        '{48'd50,          30'd1000,       8'd0,  2'd0, -32'sd500000000,48'd50,           30'd1000},       // R11
        '{48'd3,           30'd0,          8'd0,  2'd0, -32'sd17,       48'd2,            30'd999999983},  // R9
        '{48'd0,           30'd0,          8'd0,  2'd0, -32'sd16,       48'd0,            30'h3FFFFFF0}    // R10
    };

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [1:0] addr, input logic [31:0] data);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 32'd0;
    endtask

    task automatic do_cmd(input logic [1:0] cmd);
        wr(2'd3, {30'd0, cmd});
        @(negedge clk);
    endtask

    task automatic load_time(input logic [47:0] s, input logic [29:0] n);
        wr(2'd2, {16'd0, s[47:32]});
        wr(2'd1, s[31:0]);
        wr(2'd0, {2'd0, n});
        do_cmd(2'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    logic [47:0] snap_sec;
    logic [29:0] snap_ns;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(live_sec == 0 && live_ns == 0, "R1 live", {live_sec[33:0], live_ns}, 64'd0);
        check(acc_sec_hi == 0 && acc_sec_lo == 0 && acc_ns == 0 && act_pend == 0, "R1 staging",
              {acc_sec_hi, acc_sec_lo[15:0], acc_ns[15:0], 14'd0, act_pend}, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            load_time(VECS[i].sec, VECS[i].ns);
            if (VECS[i].nticks != 0) begin
                tick = 1'b1;
                corr_valid = (VECS[i].corr != 2'd0);
                corr_slow  = (VECS[i].corr == 2'd2);
                repeat (VECS[i].nticks) @(negedge clk);
                tick = 1'b0; corr_valid = 1'b0; corr_slow = 1'b0;
            end
            wr(2'd0, VECS[i].delta);
            do_cmd(2'd3);
            do_cmd(2'd1);
            check(live_sec == VECS[i].exp_sec && live_ns == VECS[i].exp_ns, $sformatf("R2/R3/R8-R11 live vec%0d", i),
                  {live_sec[33:0], live_ns}, {VECS[i].exp_sec[33:0], VECS[i].exp_ns});
            check({acc_sec_hi, acc_sec_lo} == VECS[i].exp_sec && acc_ns == VECS[i].exp_ns, $sformatf("R6 saved vec%0d", i),
                  {acc_sec_lo[29:0], 4'd0, acc_ns}, {VECS[i].exp_sec[29:0], 4'd0, VECS[i].exp_ns});
        end

        // R10: held negative value (-16) resolves through ticks within the same second
        tick = 1'b1;
        @(negedge clk);
        check(live_sec == 0 && live_ns == 30'h3FFFFFF8, "R10 first tick", {live_sec[33:0], live_ns}, {34'd0, 30'h3FFFFFF8});
        @(negedge clk);
        tick = 1'b0;
        check(live_sec == 0 && live_ns == 30'd0, "R10 second tick", {live_sec[33:0], live_ns}, 64'd0);

        // R4: address decode and field widths
        wr(2'd2, 32'hDEADABCD);
        wr(2'd0, 32'hFFFFFFFF);
        wr(2'd1, 32'h13572468);
        check(acc_sec_hi == 16'hABCD, "R4 upper seconds", {48'd0, acc_sec_hi}, 64'hABCD);
        check(acc_ns == 30'h3FFFFFFF, "R4 nanoseconds", {34'd0, acc_ns}, {34'd0, 30'h3FFFFFFF});
        check(acc_sec_lo == 32'h13572468, "R4 lower seconds", {32'd0, acc_sec_lo}, 64'h13572468);
        check(live_sec == 0 && live_ns == 0, "R4 writes leave live time", {live_sec[33:0], live_ns}, 64'd0);

        // R5: command pending for exactly one cycle
        wr(2'd3, 32'd1);
        check(act_pend == 2'd1, "R5 pending", {62'd0, act_pend}, 64'd1);
        @(negedge clk);
        check(act_pend == 2'd0, "R5 back to idle", {62'd0, act_pend}, 64'd0);

        // R7: tick during load execution is dropped
        wr(2'd2, 32'd0);
        wr(2'd1, 32'd100);
        wr(2'd0, 32'd0);
        wr(2'd3, 32'd2);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check(live_sec == 48'd100 && live_ns == 30'd0, "R7 load wins over tick", {live_sec[33:0], live_ns}, {34'd100, 30'd0});

        // R6: capture while the clock is running
        tick = 1'b1;
        repeat (3) @(negedge clk);
        wr(2'd3, 32'd1);
        snap_sec = live_sec; snap_ns = live_ns;
        @(negedge clk);
        check(acc_ns == snap_ns && {acc_sec_hi, acc_sec_lo} == snap_sec, "R6 running capture",
              {34'd0, acc_ns}, {34'd0, snap_ns});
        check(live_ns == snap_ns + 30'd8, "R2 clock kept running", {34'd0, live_ns}, {34'd0, snap_ns + 30'd8});
        tick = 1'b0;

        // R1: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        check(live_sec == 0 && live_ns == 0 && acc_ns == 0 && act_pend == 0, "R1 reset again",
              {live_sec[33:0], live_ns}, 64'd0);
        rst = 1'b0;

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule